// File: doc/BRIEF.md
# Multi-Channel Countdown Timer Bank

This block holds eight independent down-counters of 32 bits each, reached through a word-addressed register port. Every channel has a live count register, a reload register and two compare registers. A channel counts down once per bus clock cycle or once per slow tick. When the count reaches zero, the channel reloads and can flag an interrupt. A prescaler divides the bus clock by `TICK_DIV` to make the slow tick, which is a 1 MHz time base when `TICK_DIV` matches the bus clock in MHz.

The control bits of all channels share one 32-bit word, four bits per channel. Software can set bits by writing that word. It can drop bits without a read-modify-write by writing ones to a separate clear alias. In the register map, the blocks of channels 1 to 3 come first. The shared control words and the clear alias follow them, and the blocks of channels 4 to 8 come last. Each channel also has two sticky compare flags, which come out on pins for the interrupt logic around the block.

Top module: `tmr_bank`

## Requirements
- R1: Word addresses: channel n in 1..3 starts at word 4(n-1), and channel n in 4..8 starts at word 16+4(n-4). Inside a channel block, offset 0 is the live count, 1 the reload, 2 compare A and 3 compare B. Word 12 is control 1, 13 control 2, 14 control 3 and 15 the clear alias, which reads as zero. Registers do not alias one another.
- R2: Channel n owns bits 4(n-1)..4(n-1)+3 of control 1. Within that nibble, bit 0 is run, bit 1 selects the slow tick as the count source, bit 2 is the wrap-interrupt enable and bit 3 is the PWM select.
- R3: After the synchronous reset, every register, count, interrupt pin and compare flag is zero.
- R4: When run changes from 0 to 1, the count loads the reload value at that write's clock edge. With the bus clock selected, the count then drops by one at every following edge.
- R5: When a running count is zero, the next count step loads the reload value, so a reload of R gives a period of R+1 steps.
- R6: The step that reloads from zero drives the channel's interrupt bit (`irq_pulse` bit n-1) high for exactly one cycle if the interrupt enable is set. If the enable is clear, that bit stays low.
- R7: With the slow tick selected, the count drops by exactly N over any window of N*TICK_DIV clock edges.
- R8: Clearing run freezes the count at its value. Setting run again reloads the count.
- R9: A write to the clear alias zeroes every control-1 bit written as 1 and leaves the bits written as 0 unchanged.
- R10: On channels whose bit in `PWM_CH_MASK` is 0, the PWM select bit is reserved: it ignores writes and reads as 0. The default mask gives PWM to channels 4 to 8.
- R11: While a channel runs, a count equal to compare A sets `match_hit` bit 2(n-1), and a count equal to compare B sets bit 2(n-1)+1. The flag is set one edge after the equality. It stays set until the matching compare register is written.
- R12: Writes to a live count register are ignored. Control 2 and control 3 store and read back the written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe, applied at the rising edge |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq_pulse | output | NUM_CH | One-cycle wrap interrupt per channel |
| match_hit | output | 2*NUM_CH | Sticky compare flags, two per channel |

## Verification
A write takes effect at the edge where `bus_wr` is sampled, and reads are combinational. The bench therefore drives writes at the falling edge and reads back one falling edge later, with no extra wait. A channel started with reload R shows R right after the starting write and R-k after k further edges. Its interrupt bit rises after edge R+1 and then after every R+1 edges, and its compare flag appears one edge after the count equals the compare value. For the slow tick, the bench waits a whole number of prescaler periods, so the expected count comes out the same at any prescaler phase.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int DATA_W   = 32;
    localparam int WADDR_W  = 6;
    localparam int MAX_CH   = 8;
    localparam int LOW_CH   = 3;   // channels placed before the control words
    localparam int CTRL_BASE = 12;
    localparam int HIGH_BASE = 16;

    typedef enum logic [1:0] {
        RK_NONE = 2'd0,
        RK_CHAN = 2'd1,
        RK_CTRL = 2'd2
    } reg_kind_e;

    // field select inside a channel block
    localparam logic [1:0] F_COUNT  = 2'd0;
    localparam logic [1:0] F_RELOAD = 2'd1;
    localparam logic [1:0] F_CMPA   = 2'd2;
    localparam logic [1:0] F_CMPB   = 2'd3;

    // field select inside the control group
    localparam logic [1:0] C_WORD1 = 2'd0;
    localparam logic [1:0] C_WORD2 = 2'd1;
    localparam logic [1:0] C_WORD3 = 2'd2;
    localparam logic [1:0] C_CLR1  = 2'd3;

    typedef struct packed {
        logic pwm;
        logic irq_en;
        logic use_tick;
        logic run;
    } ctl_nib_t;

    typedef struct packed {
        reg_kind_e  kind;
        logic [2:0] ch;
        logic [1:0] sel;
    } reg_dec_t;

    function automatic reg_dec_t decode_word(input logic [WADDR_W-1:0] w,
                                             input int num_ch);
        reg_dec_t d;
        logic [WADDR_W-1:0] rel;
        d   = '{kind: RK_NONE, ch: 3'd0, sel: w[1:0]};
        rel = w - WADDR_W'(HIGH_BASE);
        if (int'(w) < CTRL_BASE) begin
            d.kind = RK_CHAN;
            d.ch   = w[4:2];
        end else if (int'(w) < HIGH_BASE) begin
            d.kind = RK_CTRL;
        end else if (int'(w) < HIGH_BASE + 4 * (num_ch - LOW_CH)) begin
            d.kind = RK_CHAN;
            d.ch   = rel[4:2] + 3'(LOW_CH);
        end
        return d;
    endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int DIV = 50
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pcnt_q;

    always_ff @(posedge clk) begin
        if (rst)                 pcnt_q <= '0;
        else if (pcnt_q == LAST) pcnt_q <= '0;
        else                     pcnt_q <= pcnt_q + 1'b1;
    end

    assign tick_o = (pcnt_q == LAST);

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);  // R7

endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter logic [MAX_CH-1:0] PWM_CH_MASK = 8'hF8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_word1,
    input  logic              wr_word2,
    input  logic              wr_word3,
    input  logic              wr_clr1,
    input  logic [DATA_W-1:0] wdata,
    output logic [4*NUM_CH-1:0] word1_q,
    output logic [DATA_W-1:0] word2_q,
    output logic [DATA_W-1:0] word3_q,
    output logic [NUM_CH-1:0] start_o
);
    localparam int CTL_W = 4 * NUM_CH;

    logic [CTL_W-1:0] keep_mask;
    logic [CTL_W-1:0] wd;

    assign wd = wdata[CTL_W-1:0];

    for (genvar k = 0; k < NUM_CH; k++) begin : g_nib
        assign keep_mask[4*k +: 3] = 3'b111;
        assign keep_mask[4*k + 3]  = PWM_CH_MASK[k];
        assign start_o[k] = wr_word1 & wd[4*k] & ~word1_q[4*k];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word1_q <= '0;
            word2_q <= '0;
            word3_q <= '0;
        end else begin
            if (wr_word1)     word1_q <= wd & keep_mask;
            else if (wr_clr1) word1_q <= word1_q & ~wd;
            if (wr_word2)     word2_q <= wdata;
            if (wr_word3)     word3_q <= wdata;
        end
    end

    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (rst)
        wr_clr1 && !wr_word1 |=> (word1_q & $past(wd)) == '0);  // R9
    AST_CLR_KEEPS: assert property (@(posedge clk) disable iff (rst)
        wr_clr1 && !wr_word1 |=> (word1_q & ~$past(wd)) == ($past(word1_q) & ~$past(wd)));  // R9

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ctl_nib_t          ctl_i,
    input  logic              tick_i,
    input  logic              start_i,
    input  logic              wr_reload_i,
    input  logic              wr_cmpa_i,
    input  logic              wr_cmpb_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] cnt_o,
    output logic [DATA_W-1:0] reload_o,
    output logic [DATA_W-1:0] cmpa_o,
    output logic [DATA_W-1:0] cmpb_o,
    output logic              irq_o,
    output logic [1:0]        hit_o
);
    logic [DATA_W-1:0] cnt_q, reload_q, cmpa_q, cmpb_q;
    logic              step;

    assign step = ctl_i.run & (ctl_i.use_tick ? tick_i : 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= '0;
            cmpa_q   <= '0;
            cmpb_q   <= '0;
        end else begin
            if (wr_reload_i) reload_q <= wdata_i;
            if (wr_cmpa_i)   cmpa_q   <= wdata_i;
            if (wr_cmpb_i)   cmpb_q   <= wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            irq_o <= 1'b0;
        end else begin
            irq_o <= 1'b0;
            if (start_i) begin
                cnt_q <= reload_q;
            end else if (step) begin
                if (cnt_q == '0) begin
                    cnt_q <= reload_q;
                    irq_o <= ctl_i.irq_en;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_o <= 2'b00;
        end else begin
            if (wr_cmpa_i)                           hit_o[0] <= 1'b0;
            else if (ctl_i.run && cnt_q == cmpa_q)   hit_o[0] <= 1'b1;
            if (wr_cmpb_i)                           hit_o[1] <= 1'b0;
            else if (ctl_i.run && cnt_q == cmpb_q)   hit_o[1] <= 1'b1;
        end
    end

    assign cnt_o    = cnt_q;
    assign reload_o = reload_q;
    assign cmpa_o   = cmpa_q;
    assign cmpb_o   = cmpb_q;

    AST_FREEZE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !ctl_i.run && !start_i |=> $stable(cnt_q));  // R8
    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
        ctl_i.run && !ctl_i.use_tick && !start_i && cnt_q != '0 |=> cnt_q == $past(cnt_q) - 1'b1);  // R4
    AST_IRQ_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> cnt_q == $past(reload_q));  // R6
    AST_HIT_STICKY: assert property (@(posedge clk) disable iff (rst)
        hit_o[0] && !wr_cmpa_i |=> hit_o[0]);  // R11

endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
    import tmr_pkg::*;
#(
    parameter int NUM_CH   = 8,
    parameter int TICK_DIV = 50,
    parameter logic [MAX_CH-1:0] PWM_CH_MASK = 8'hF8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_wr,
    input  logic [WADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic [NUM_CH-1:0]     irq_pulse,
    output logic [2*NUM_CH-1:0]   match_hit
);
    localparam int CTL_W = 4 * NUM_CH;

    reg_dec_t          dec;
    logic              tick;
    logic [CTL_W-1:0]  word1;
    logic [DATA_W-1:0] word2, word3;
    logic [NUM_CH-1:0] start;
    logic              ctrl_hit;

    logic [DATA_W-1:0] ch_cnt    [NUM_CH];
    logic [DATA_W-1:0] ch_reload [NUM_CH];
    logic [DATA_W-1:0] ch_cmpa   [NUM_CH];
    logic [DATA_W-1:0] ch_cmpb   [NUM_CH];

    assign dec      = decode_word(bus_addr, NUM_CH);
    assign ctrl_hit = bus_wr && dec.kind == RK_CTRL;

    tmr_prescale #(.DIV(TICK_DIV)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick)
    );

    tmr_ctrl #(.NUM_CH(NUM_CH), .PWM_CH_MASK(PWM_CH_MASK)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr_word1 (ctrl_hit && dec.sel == C_WORD1),
        .wr_word2 (ctrl_hit && dec.sel == C_WORD2),
        .wr_word3 (ctrl_hit && dec.sel == C_WORD3),
        .wr_clr1  (ctrl_hit && dec.sel == C_CLR1),
        .wdata    (bus_wdata),
        .word1_q  (word1),
        .word2_q  (word2),
        .word3_q  (word3),
        .start_o  (start)
    );

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        logic sel_me;
        assign sel_me = bus_wr && dec.kind == RK_CHAN && dec.ch == 3'(k);

        tmr_channel u_ch (
            .clk         (clk),
            .rst         (rst),
            .ctl_i       (ctl_nib_t'(word1[4*k +: 4])),
            .tick_i      (tick),
            .start_i     (start[k]),
            .wr_reload_i (sel_me && dec.sel == F_RELOAD),
            .wr_cmpa_i   (sel_me && dec.sel == F_CMPA),
            .wr_cmpb_i   (sel_me && dec.sel == F_CMPB),
            .wdata_i     (bus_wdata),
            .cnt_o       (ch_cnt[k]),
            .reload_o    (ch_reload[k]),
            .cmpa_o      (ch_cmpa[k]),
            .cmpb_o      (ch_cmpb[k]),
            .irq_o       (irq_pulse[k]),
            .hit_o       (match_hit[2*k +: 2])
        );
    end

    always_comb begin
        bus_rdata = '0;
        case (dec.kind)
            RK_CHAN: begin
                case (dec.sel)
                    F_COUNT:  bus_rdata = ch_cnt[dec.ch];
                    F_RELOAD: bus_rdata = ch_reload[dec.ch];
                    F_CMPA:   bus_rdata = ch_cmpa[dec.ch];
                    default:  bus_rdata = ch_cmpb[dec.ch];
                endcase
            end
            RK_CTRL: begin
                case (dec.sel)
                    C_WORD1: bus_rdata = DATA_W'(word1);
                    C_WORD2: bus_rdata = word2;
                    C_WORD3: bus_rdata = word3;
                    default: bus_rdata = '0;
                endcase
            end
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: tb/test_tmr_bank.sv
module test_tmr_bank;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 8;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NCH-1:0]   irq_pulse;
    logic [2*NCH-1:0] match_hit;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_bank #(.NUM_CH(NCH), .TICK_DIV(DIV), .PWM_CH_MASK(8'hF8)) i_tmr_bank (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_pulse (irq_pulse),
        .match_hit (match_hit)
    );

    function automatic logic [5:0] chw(input int n, input int f);
        return (n <= 3) ? 6'(4*(n-1) + f) : 6'(16 + 4*(n-4) + f);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(6'd12, v);       check("R3 ctrl1 after reset", v, 0);
        rd(chw(1,0), v);    check("R3 count after reset", v, 0);
        check("R3 irq after reset", 32'(irq_pulse), 0);
        check("R3 hits after reset", 32'(match_hit), 0);
    endtask

    task automatic t_map;
        logic [31:0] v;
        for (int n = 1; n <= NCH; n++) wr(chw(n,1), 32'h1000 + 32'(n));
        for (int n = 1; n <= NCH; n++) begin
            rd(chw(n,1), v); check("R1 reload map", v, 32'h1000 + 32'(n));
        end
        rd(6'd12, v); check("R1 ctrl1 not aliased", v, 0);
        wr(6'd13, 32'hA5A5_0001); wr(6'd14, 32'h5A5A_0002);
        rd(6'd13, v); check("R12 ctrl2 readback", v, 32'hA5A5_0001);
        rd(6'd14, v); check("R12 ctrl3 readback", v, 32'h5A5A_0002);
        rd(6'd15, v); check("R1 clear alias reads zero", v, 0);
    endtask

    task automatic t_run_freeze;
        logic [31:0] v;
        wr(chw(1,1), 32'd100);
        wr(6'd12, 32'h0);
        wr(6'd12, 32'h1);
        rd(chw(1,0), v); check("R4 load on start", v, 100);
        repeat (5) @(negedge clk);
        rd(chw(1,0), v); check("R4 count down per cycle", v, 95);
        wr(6'd12, 32'h0);
        rd(chw(1,0), v); check("R8 value at stop", v, 93);
        repeat (10) @(negedge clk);
        rd(chw(1,0), v); check("R8 frozen", v, 93);
        wr(6'd12, 32'h1);
        rd(chw(1,0), v); check("R8 reload on restart", v, 100);
    endtask

    task automatic t_irq;
        logic [31:0] v;
        wr(chw(2,1), 32'd3);
        wr(6'd12, 32'h0);
        wr(6'd12, 32'h50);   // R2 channel 2 nibble: run + irq enable
        for (int k = 1; k <= 9; k++) begin
            @(negedge clk);
            check("R6 irq pulse timing", 32'(irq_pulse), (k % 4 == 0) ? 32'h2 : 32'h0);
            if (k == 4) begin
                rd(chw(2,0), v); check("R5 reload after zero", v, 3);
            end
        end
        wr(6'd12, 32'h0);
        wr(6'd12, 32'h10);   // run without irq enable
        for (int k = 1; k <= 9; k++) begin
            @(negedge clk);
            check("R6 no irq when disabled", 32'(irq_pulse), 0);
        end
    endtask

    task automatic t_tick;
        logic [31:0] v;
        wr(6'd12, 32'h0);
        wr(chw(3,1), 32'd50);
        wr(6'd12, 32'h300);  // R2 channel 3: run + slow tick
        rd(chw(3,0), v); check("R7 load", v, 50);
        repeat (5*DIV) @(negedge clk);
        rd(chw(3,0), v); check("R7 tick rate", v, 45);
    endtask

    task automatic t_clear;
        logic [31:0] v;
        wr(6'd12, 32'hFFFF_FFFF);
        rd(6'd12, v); check("R10 reserved pwm bits", v, 32'hFFFF_F777);
        wr(6'd15, 32'h0F0F_0F0F);
        rd(6'd12, v); check("R9 clear alias", v, 32'hF0F0_F070);
        wr(6'd12, 32'h0);
    endtask

    task automatic t_match;
        logic [31:0] v, w;
        wr(chw(4,2), 32'd15);
        wr(chw(4,3), 32'd30);
        wr(chw(4,1), 32'd20);
        check("R11 flags cleared by writes", 32'(match_hit[7:6]), 0);
        wr(6'd12, 32'h1000);
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            check("R11 compare A flag", 32'(match_hit[6]), (k >= 6) ? 1 : 0);
            check("R11 compare B flag", 32'(match_hit[7]), 0);
        end
        wr(chw(4,2), 32'd15);
        check("R11 write clears flag", 32'(match_hit[6]), 0);
        wr(6'd12, 32'h0);
        rd(chw(4,0), v);
        wr(chw(4,0), 32'hDEAD_BEEF);
        rd(chw(4,0), w); check("R12 count write ignored", w, v);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_map();
        t_run_freeze();
        t_irq();
        t_tick();
        t_clear();
        t_match();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule